// File: doc/BRIEF.md
# Segment Translation Table Associative Search

This block keeps a small, fully associative table of segment translation entries and searches all of them at once for a 64-bit effective address. The match rule is the one used when the address is being translated. Each entry carries its own segment-size code, so the number of address bits compared differs from one entry to the next. Each entry also holds a tag-active bit, which must agree with one bit of the address. Software-visible loads and invalidations reach the table through a single indexed write port. A separate strobe clears every entry at once.

A search is presented with a strobe and the address operand. One clock later a registered result appears. It is either the packed translation fields of the matching entry or all zeros when nothing matched. It comes with a found flag and a separate multi-hit error flag. When several entries match, the lowest-index one supplies the result and the error flag is raised, so that a surrounding pipeline can choose to raise a machine check.

Top module: `seg_lookaside_search`

## Requirements
- R1: A synchronous reset clears the valid bit of every entry and drives res_valid, res_word, res_found and res_multi to zero.
- R2: An entry whose valid bit is 0 never matches, whatever its other fields hold.
- R3: Size code 0 (256 MB segments) compares srch_ea[63:28] with all 36 stored ESID bits. Size code 1 (1 TB segments) compares srch_ea[63:40] with stored ESID bits [35:12] and ignores ESID bits [11:0]. Size codes 2 and 3 never match. Address bits below the compared range have no effect.
- R4: An entry matches only if srch_ea[24] equals the entry's tag-active bit. Bit 24 is bit 39 when bits are numbered from the most significant end.
- R5: On exactly one match, res_word holds size code in [63:62], VSID in [61:12], the five protection/attribute bits (wr_prot[4:0]) in [11:7], tag-active in [6], and LP in [5:4]. Bits [3:0] are zero. res_found is 1 and res_multi is 0.
- R6: With no match, res_word is exactly zero and res_found and res_multi are 0.
- R7: With two or more matches, res_word is packed from the lowest-index matching entry, and res_found and res_multi are both 1.
- R8: res_valid is 1 exactly one clock after a cycle with srch_valid high and 0 otherwise. res_word, res_found and res_multi change only one clock after a search and hold their values in between.
- R9: A write or invalidate-all in the same cycle as a search does not affect that search. It takes effect for the next one.
- R10: inv_all clears every valid bit in one cycle. It takes precedence over a write in the same cycle.
- R11: A write with wr_valid = 0 invalidates the addressed entry and leaves all other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the indexed entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid bit to store (0 invalidates) |
| wr_esid | input | 36 | Effective segment ID to store |
| wr_size | input | 2 | Segment-size code to store |
| wr_vsid | input | 50 | Virtual segment ID to store |
| wr_prot | input | 5 | Ks, Kp, N, L, C bits, Ks in bit 4 |
| wr_ta | input | 1 | Tag-active bit to store |
| wr_lp | input | 2 | Large-page selector to store |
| inv_all | input | 1 | Clear every valid bit |
| srch_valid | input | 1 | Search strobe |
| srch_ea | input | 64 | Effective-address operand |
| res_valid | output | 1 | Result present this cycle |
| res_word | output | 64 | Packed result word |
| res_found | output | 1 | At least one entry matched |
| res_multi | output | 1 | More than one entry matched |

## Verification
Two situations are hardest to reach from the ports. The first is a search with several matching entries whose sizes differ, so that a 1 TB entry and a 256 MB entry both cover the same address. The second is an update landing in the same cycle as the search it must not disturb. The bench loads entries with deliberate overlaps, including 1 TB entries whose low ESID bits differ from the address. It then issues searches in the very cycle a matching entry is invalidated, overwritten or swept by inv_all. A long random phase draws ESIDs from a pool of four values so that duplicates, and therefore multi-hits, arise often. A behavioural model is compared with the outputs every clock.

// File: rtl/seglook_pkg.sv
package seglook_pkg;
  localparam int EA_W        = 64;
  localparam int SMALL_SHIFT = 28;
  localparam int LARGE_SHIFT = 40;
  localparam int ESID_W      = EA_W - SMALL_SHIFT;
  localparam int LG_CMP_W    = EA_W - LARGE_SHIFT;
  localparam int TA_BE_POS   = 39;
  localparam int TA_LE_POS   = EA_W - 1 - TA_BE_POS;
  localparam int SIZE_W      = 2;
  localparam int VSID_W      = 50;
  localparam int PROT_W      = 5;
  localparam int LP_W        = 2;
  localparam int PAD_W       = EA_W - SIZE_W - VSID_W - PROT_W - 1 - LP_W;

  localparam logic [SIZE_W-1:0] SZ_256M = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_1T   = 2'd1;

  typedef struct packed {
    logic [ESID_W-1:0] esid;
    logic [SIZE_W-1:0] size;
    logic [VSID_W-1:0] vsid;
    logic [PROT_W-1:0] prot;
    logic              ta;
    logic [LP_W-1:0]   lp;
  } seg_entry_t;

  function automatic logic [EA_W-1:0] pack_result(seg_entry_t e);
    return {e.size, e.vsid, e.prot, e.ta, e.lp, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/seglook_entry_match.sv
module seglook_entry_match
  import seglook_pkg::*;
(
  input  logic              ent_valid,
  input  logic [ESID_W-1:0] ent_esid,
  input  logic [SIZE_W-1:0] ent_size,
  input  logic              ent_ta,
  input  logic [ESID_W-1:0] ea_hi,
  input  logic              ea_ta,
  output logic              hit
);
  logic tag_eq;

  always_comb begin
    case (ent_size)
      SZ_256M: tag_eq = (ea_hi == ent_esid);
      SZ_1T:   tag_eq = (ea_hi[ESID_W-1 -: LG_CMP_W] == ent_esid[ESID_W-1 -: LG_CMP_W]);
      default: tag_eq = 1'b0;
    endcase
    hit = ent_valid & tag_eq & (ea_ta == ent_ta);
  end
endmodule

// File: rtl/seglook_prio_sel.sv
module seglook_prio_sel #(
  parameter  int N_ENTRIES = 32,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] hits,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 any_hit,
  output logic                 multi_hit
);
  always_comb begin
    sel_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) sel_idx = IDX_W'(i);
    end
    any_hit   = |hits;
    multi_hit = (hits & (hits - N_ENTRIES'(1))) != '0;
  end
endmodule

// File: rtl/seg_lookaside_search.sv
module seg_lookaside_search
  import seglook_pkg::*;
#(
  parameter  int N_ENTRIES = 32,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [35:0]       wr_esid,
  input  logic [1:0]        wr_size,
  input  logic [49:0]       wr_vsid,
  input  logic [4:0]        wr_prot,
  input  logic              wr_ta,
  input  logic [1:0]        wr_lp,
  input  logic              inv_all,
  input  logic              srch_valid,
  input  logic [63:0]       srch_ea,
  output logic              res_valid,
  output logic [63:0]       res_word,
  output logic              res_found,
  output logic              res_multi
);
  logic [N_ENTRIES-1:0] valid_q;
  seg_entry_t           ent_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]     sel_idx;
  logic                 any_hit;
  logic                 multi_hit;
  logic                 unused_ea;

  assign unused_ea = ^{srch_ea[SMALL_SHIFT-1:TA_LE_POS+1], srch_ea[TA_LE_POS-1:0]};

  // valid bits: reset and invalidate-all need flops
  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
    end
  end

  // payload: plain indexed write, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_q[wr_idx] <= '{esid: wr_esid, size: wr_size, vsid: wr_vsid,
                         prot: wr_prot, ta: wr_ta, lp: wr_lp};
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_match
    seglook_entry_match u_match (
      .ent_valid (valid_q[g]),
      .ent_esid  (ent_q[g].esid),
      .ent_size  (ent_q[g].size),
      .ent_ta    (ent_q[g].ta),
      .ea_hi     (srch_ea[EA_W-1:SMALL_SHIFT]),
      .ea_ta     (srch_ea[TA_LE_POS]),
      .hit       (hit_vec[g])
    );
  end

  seglook_prio_sel #(.N_ENTRIES(N_ENTRIES)) u_prio (
    .hits      (hit_vec),
    .sel_idx   (sel_idx),
    .any_hit   (any_hit),
    .multi_hit (multi_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      res_found <= 1'b0;
      res_multi <= 1'b0;
    end else begin
      res_valid <= srch_valid;
      if (srch_valid) begin
        res_word  <= any_hit ? pack_result(ent_q[sel_idx]) : '0;
        res_found <= any_hit;
        res_multi <= multi_hit;
      end
    end
  end

  // selected entry is a hit and no lower-index entry hit (R7)
  assert_lowest_sel_R7: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hit_vec[sel_idx] &&
                 ((hit_vec & ((N_ENTRIES'(1) << sel_idx) - N_ENTRIES'(1))) == '0)));

  assert_multi_found_R7: assert property (@(posedge clk) disable iff (rst)
    res_multi |-> res_found);

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_found) |-> (res_word == '0));

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(srch_valid)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !srch_valid |=> ($stable(res_word) && $stable(res_found) && $stable(res_multi)));

  assert_inv_all_R10: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_q == '0));
endmodule

// File: tb/tb_seg_lookaside_search.sv
module tb_seg_lookaside_search;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_valid, wr_ta, inv_all, srch_valid;
  logic [4:0]  wr_idx;
  logic [35:0] wr_esid;
  logic [1:0]  wr_size, wr_lp;
  logic [49:0] wr_vsid;
  logic [4:0]  wr_prot;
  logic [63:0] srch_ea;
  logic        res_valid, res_found, res_multi;
  logic [63:0] res_word;

  always #4 clk = ~clk;

  seg_lookaside_search #(.N_ENTRIES(N)) dut (.*);

  int checks = 0;
  int failures = 0;

  // behavioural model
  bit          m_v    [N];
  logic [35:0] m_esid [N];
  logic [1:0]  m_size [N];
  logic [49:0] m_vsid [N];
  logic [4:0]  m_prot [N];
  logic        m_ta   [N];
  logic [1:0]  m_lp   [N];
  logic        e_rv = 0, e_found = 0, e_multi = 0;
  logic [63:0] e_word = '0;

  function automatic bit m_hit(int i, logic [63:0] ea);
    if (!m_v[i] || ea[24] !== m_ta[i]) return 0;
    if (m_size[i] == 2'd0) return (ea >> 28) == 64'(m_esid[i]);
    if (m_size[i] == 2'd1) return (ea >> 40) == 64'(m_esid[i] >> 12);
    return 0;
  endfunction

  task automatic idle_inputs();
    wr_en = 0; wr_valid = 0; wr_idx = '0; wr_esid = '0; wr_size = '0;
    wr_vsid = '0; wr_prot = '0; wr_ta = 0; wr_lp = '0;
    inv_all = 0; srch_valid = 0; srch_ea = '0;
  endtask

  // one clock: expected from pre-update model, then update, then compare
  task automatic cycle(string tag);
    int cnt = 0;
    int first = -1;
    e_rv = srch_valid;
    if (srch_valid) begin
      for (int i = 0; i < N; i++) if (m_hit(i, srch_ea)) begin
        cnt++;
        if (first < 0) first = i;
      end
      e_found = (cnt > 0);
      e_multi = (cnt > 1);
      e_word  = (cnt > 0) ? {m_size[first], m_vsid[first], m_prot[first],
                             m_ta[first], m_lp[first], 4'b0000} : 64'd0;
    end
    if (inv_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (wr_en) begin
      m_v[wr_idx] = wr_valid;
    end
    if (wr_en) begin
      m_esid[wr_idx] = wr_esid; m_size[wr_idx] = wr_size; m_vsid[wr_idx] = wr_vsid;
      m_prot[wr_idx] = wr_prot; m_ta[wr_idx] = wr_ta; m_lp[wr_idx] = wr_lp;
    end
    @(posedge clk);
    #1;
    checks++;
    if (res_valid !== e_rv || res_word !== e_word ||
        res_found !== e_found || res_multi !== e_multi) begin
      failures++;
      $display("FAIL %s: actual v=%b w=%h f=%b m=%b expected v=%b w=%h f=%b m=%b",
               tag, res_valid, res_word, res_found, res_multi,
               e_rv, e_word, e_found, e_multi);
    end
    idle_inputs();
  endtask

  task automatic set_wr(int idx, bit v, logic [35:0] esid, logic [1:0] sz,
                        logic [49:0] vsid, logic [4:0] prot, bit ta, logic [1:0] lp);
    wr_en = 1; wr_idx = 5'(idx); wr_valid = v; wr_esid = esid; wr_size = sz;
    wr_vsid = vsid; wr_prot = prot; wr_ta = ta; wr_lp = lp;
  endtask

  task automatic set_srch(logic [63:0] ea);
    srch_valid = 1; srch_ea = ea;
  endtask

  function automatic logic [63:0] ea_small(logic [35:0] esid, bit ta);
    logic [63:0] ea = {esid, 28'($urandom)};
    ea[24] = ta;
    return ea;
  endfunction

  function automatic logic [63:0] ea_large(logic [35:0] esid, bit ta);
    logic [63:0] ea = {esid[35:12], 40'({$urandom, $urandom})};
    ea[24] = ta;
    return ea;
  endfunction

  logic [35:0] EA_A = 36'h1_2345_6789;
  logic [35:0] EA_B = 36'hA_BCDE_F012;
  logic [35:0] pool [4];
  logic [63:0] ea;

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_esid[i] = '0; m_size[i] = '0; m_vsid[i] = '0;
      m_prot[i] = '0; m_ta[i] = 0; m_lp[i] = '0;
    end
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    cycle("R1 reset state");
    set_srch(64'h0); cycle("R1 search after reset misses");

    // size 0 entry, single hit with random low bits (R3, R5)
    set_wr(3, 1, EA_A, 2'd0, 50'h2_AAAA_5555_1234, 5'b10110, 0, 2'd2); cycle("R5 write");
    set_srch(ea_small(EA_A, 0)); cycle("R5 single hit size0");
    set_srch(ea_small(EA_A, 0)); cycle("R3 low bits ignored size0");
    set_srch(ea_small(EA_A, 1)); cycle("R4 ta mismatch misses");
    set_srch(ea_small(EA_A ^ 36'h1, 0)); cycle("R3 esid lsb differs size0");
    cycle("R8 idle holds");

    // size 1 entry whose low ESID bits differ from the address (R3)
    set_wr(5, 1, EA_B, 2'd1, 50'h1_0000_0000_00FF, 5'b01001, 1, 2'd1); cycle("R3 write");
    set_srch(ea_large(EA_B ^ 36'h0_0000_0ABC, 1)); cycle("R3 size1 ignores esid low bits");
    set_srch(ea_large(EA_B, 0)); cycle("R4 size1 ta mismatch");
    set_srch(ea_large(EA_B ^ 36'h0_0000_1000, 1)); cycle("R3 size1 bit40 differs");

    // size codes 2 and 3 never match
    set_wr(7, 1, EA_A, 2'd2, 50'h3, 5'h1F, 0, 2'd3); cycle("R3 write sz2");
    set_wr(8, 1, EA_A, 2'd3, 50'h4, 5'h1F, 0, 2'd3); cycle("R3 write sz3");
    set_wr(3, 0, EA_A, 2'd0, 50'h0, 5'h0, 0, 2'd0); cycle("R11 invalidate 3");
    set_srch(ea_small(EA_A, 0)); cycle("R3 sizes 2/3 never match");

    // invalid entry with matching fields (R2)
    set_wr(9, 0, EA_A, 2'd0, 50'h9, 5'h3, 0, 2'd0); cycle("R2 write invalid");
    set_srch(ea_small(EA_A, 0)); cycle("R2 invalid entry no match");

    // multi-hit across sizes: entries 12 (1TB) and 20 (256MB) overlap
    set_wr(20, 1, EA_A, 2'd0, 50'h20, 5'h14, 0, 2'd1); cycle("R7 write 20");
    set_wr(12, 1, EA_A ^ 36'h0_0000_0F0F, 2'd1, 50'h12, 5'h0C, 0, 2'd2); cycle("R7 write 12");
    set_srch(ea_small(EA_A, 0)); cycle("R7 multi lowest index");
    set_wr(12, 0, EA_A, 2'd1, 50'h12, 5'h0C, 0, 2'd2); cycle("R11 invalidate 12");
    set_srch(ea_small(EA_A, 0)); cycle("R11 other entry survives");

    // same-cycle update vs search (R9)
    ea = ea_small(EA_A, 0);
    set_srch(ea); set_wr(20, 0, EA_A, 2'd0, 50'h0, 5'h0, 0, 2'd0); cycle("R9 search sees old entry");
    set_srch(ea); cycle("R9 next search sees invalidation");
    set_wr(1, 1, EA_B, 2'd0, 50'h77, 5'h11, 1, 2'd0); set_srch(ea_small(EA_B, 1)); cycle("R9 same-cycle write unseen");
    set_srch(ea_small(EA_B, 1)); cycle("R9 write visible next");

    // inv_all with a competing write and a search (R10)
    set_srch(ea_small(EA_B, 1)); inv_all = 1;
    set_wr(2, 1, EA_B, 2'd0, 50'h88, 5'h2, 1, 2'd0); cycle("R10 search during inv_all");
    set_srch(ea_small(EA_B, 1)); cycle("R10 all cleared, write lost");
    set_srch(ea_large(EA_B, 1)); cycle("R10 size1 search misses");

    // random phase with a small ESID pool for duplicates
    pool[0] = EA_A; pool[1] = EA_B; pool[2] = 36'h0_0000_0001; pool[3] = EA_A ^ 36'h0_0000_0555;
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) set_wr($urandom_range(0, N - 1), ($urandom_range(0, 5) != 0),
                        pool[$urandom_range(0, 3)], 2'($urandom_range(0, 2)),
                        50'({$urandom, $urandom}), 5'($urandom), 1'($urandom),
                        2'($urandom));
      if (r >= 3 && r < 9) begin
        if ($urandom_range(0, 1) == 0) set_srch(ea_small(pool[$urandom_range(0, 3)], 1'($urandom)));
        else set_srch(ea_large(pool[$urandom_range(0, 3)], 1'($urandom)));
      end
      if (r == 9 && $urandom_range(0, 20) == 0) inv_all = 1;
      cycle("R5 R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule